// File: doc/BRIEF.md
# Byte Alignment Data Extractor

This unit supports software that moves 64-bit data between addresses that are not multiples of eight. It has two operations. The address operation adds two 64-bit operands, returns the sum rounded down to an 8-byte boundary, and keeps the discarded byte position in a 3-bit offset field. The data operation takes two 64-bit words as one 16-byte window and returns the eight bytes that begin at the stored offset.

Typically, software issues the address operation once to find the aligned base and the misalignment. It then loads two neighbouring aligned words and issues the data operation to pull out the unaligned word. A little-endian form of the address operation stores the negated offset, so the same extractor can be used for data that is stored in reverse byte order. The offset is held in a register between operations. It persists until the next address operation or a reset.

Top module: `byte_align_unit`

## Requirements
- R1: While reset is low, and after it is released, the offset field `ofs_o` reads 0.
- R2: For command code 1 (align address) and code 2 (align address, little-endian), `res_o` is `opa_i + opb_i` (modulo 2^64) with bits 2:0 forced to 0, in the same cycle.
- R3: A code-1 command loads bits 2:0 of `opa_i + opb_i` into `ofs_o` at the next rising clock edge.
- R4: A code-2 command loads bits 2:0 of the two's-complement negation of `opa_i + opb_i` into `ofs_o` at the next rising clock edge.
- R5: For command code 3 (align data) with offset k, `res_o` holds bytes k through k+7 of the 16-byte value `{opa_i, opb_i}`, counted from the most significant byte. Byte 0 is `opa_i[63:56]`.
- R6: For code 3 with offset 0, `res_o` equals `opa_i` exactly. No bit of `opb_i` appears.
- R7: An offset loaded by an address command is used by a code-3 command in the very next cycle. Codes 0 and 3 leave `ofs_o` unchanged.
- R8: For command code 0 (idle), `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 idle, 1 align address, 2 align address little-endian, 3 align data |
| opa_i | input | 64 | First operand; upper word for align data |
| opb_i | input | 64 | Second operand; lower word for align data |
| res_o | output | 64 | Combinational result |
| ofs_o | output | 3 | Stored byte offset field |

## Verification
The data operation has no offset input of its own, so each of the eight offsets can only be reached by first issuing an address command whose sum has the right low bits. The bench does this by issuing an address command with `opa_i = k` and `opb_i = 0`, followed at once by the data command. This sweeps every offset and also exercises the back-to-back forwarding case. Offset zero is driven with a lower word of all ones, so any leak from the lower word shows up in the result. The little-endian mode is set up with sums whose low bits are zero and nonzero, which covers the case where the negation wraps to zero.

// File: rtl/bau_pkg.sv
package bau_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE    = 2'd0,
    CMD_ADDR    = 2'd1,
    CMD_ADDR_LE = 2'd2,
    CMD_DATA    = 2'd3
  } bau_cmd_e;
endpackage

// File: rtl/bau_addr_gen.sv
module bau_addr_gen #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              le_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] neg;

  assign sum    = a_i + b_i;
  assign neg    = ~sum + {{(DATA_W-1){1'b0}}, 1'b1};
  assign addr_o = {sum[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
  assign ofs_o  = le_i ? neg[OFS_W-1:0] : sum[OFS_W-1:0];
endmodule

// File: rtl/bau_funnel.sv
module bau_funnel #(
  parameter int DATA_W = 64,
  parameter int BYTES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] out_o
);
  localparam int WIDE_W = 2 * DATA_W;

  logic [WIDE_W-1:0] wide;
  logic [DATA_W-1:0] cand [BYTES];

  assign wide = {hi_i, lo_i};

  // one fixed window per offset; offset 0 takes hi_i alone
  for (genvar k = 0; k < BYTES; k++) begin : g_win
    assign cand[k] = wide[WIDE_W-1-8*k -: DATA_W];
  end

  assign out_o = cand[ofs_i];
endmodule

// File: rtl/bau_ofs_reg.sv
module bau_ofs_reg #(
  parameter int OFS_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFS_W-1:0] d_i,
  output logic [OFS_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit
  import bau_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic [OFS_W-1:0]  ofs_o
);
  bau_cmd_e          cmd;
  logic              is_addr;
  logic [DATA_W-1:0] addr_res;
  logic [OFS_W-1:0]  ofs_nxt;
  logic [DATA_W-1:0] data_res;

  assign cmd     = bau_cmd_e'(cmd_i);
  assign is_addr = (cmd == CMD_ADDR) || (cmd == CMD_ADDR_LE);

  bau_addr_gen #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_addr (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .le_i   (cmd == CMD_ADDR_LE),
    .addr_o (addr_res),
    .ofs_o  (ofs_nxt)
  );

  bau_ofs_reg #(.OFS_W(OFS_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (is_addr),
    .d_i    (ofs_nxt),
    .q_o    (ofs_o)
  );

  bau_funnel #(.DATA_W(DATA_W), .BYTES(BYTES), .OFS_W(OFS_W)) u_fun (
    .hi_i  (opa_i),
    .lo_i  (opb_i),
    .ofs_i (ofs_o),
    .out_o (data_res)
  );

  always_comb begin
    unique case (cmd)
      CMD_ADDR, CMD_ADDR_LE: res_o = addr_res;
      CMD_DATA:              res_o = data_res;
      default:               res_o = '0;
    endcase
  end
endmodule

// File: rtl/bau_checker.sv
module bau_checker #(
  parameter int DATA_W = 64,
  parameter int OFS_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] res_o,
  input logic [OFS_W-1:0]  ofs_o
);
  logic [DATA_W-1:0] sum_c;
  logic [OFS_W-1:0]  pos_c;
  logic [OFS_W-1:0]  neg_c;

  assign sum_c = opa_i + opb_i;
  assign pos_c = sum_c[OFS_W-1:0];
  assign neg_c = OFS_W'(0) - pos_c;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_ofs: assert (ofs_o == '0);
    end
  end

  a_r2_addr_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1 || cmd_i == 2'd2) |-> res_o == {sum_c[DATA_W-1:OFS_W], {OFS_W{1'b0}}});

  a_r3_ofs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd1) |=> ofs_o == $past(pos_c));

  a_r4_ofs_load_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd2) |=> ofs_o == $past(neg_c));

  a_r6_zero_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd3 && ofs_o == '0) |-> res_o == opa_i);

  a_r7_ofs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd0 || cmd_i == 2'd3) |=> $stable(ofs_o));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == 2'd0) |-> res_o == '0);
endmodule

bind byte_align_unit bau_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_i  (cmd_i),
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .res_o  (res_o),
  .ofs_o  (ofs_o)
);

// File: tb/byte_align_unit_tb_top.sv
`timescale 1ns/1ps
module byte_align_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cmd_i = 2'd0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] res_o;
  logic [2:0]  ofs_o;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  byte_align_unit dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .cmd_i (cmd_i),
    .opa_i (opa_i), .opb_i (opb_i), .res_o (res_o), .ofs_o (ofs_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk_i);
    cmd_i = c; opa_i = a; opb_i = b;
    #1;
  endtask

  function automatic logic [63:0] ref_extract(input logic [63:0] a, input logic [63:0] b,
                                               input int k);
    logic [7:0]  bytes [16];
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      bytes[i]   = a[63-8*i -: 8];
      bytes[8+i] = b[63-8*i -: 8];
    end
    for (int j = 0; j < 8; j++) r[63-8*j -: 8] = bytes[j+k];
    return r;
  endfunction

  task automatic t_reset();
    issue(2'd1, 64'd5, 64'd0);
    issue(2'd0, 0, 0);
    chk("R3 preload", {61'd0, ofs_o}, 64'd5);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1 during reset", {61'd0, ofs_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    issue(2'd0, 0, 0);
    chk("R1 after reset", {61'd0, ofs_o}, 64'd0);
  endtask

  task automatic t_addr();
    logic [63:0] a = 64'h1234_5678_9ABC_DEF1;
    logic [63:0] b = 64'h0000_0000_0000_0014;
    logic [63:0] s = a + b;
    issue(2'd1, a, b);
    chk("R2 addr result", res_o, {s[63:3], 3'b000});
    issue(2'd0, 0, 0);
    chk("R3 addr offset", {61'd0, ofs_o}, {61'd0, s[2:0]});
    chk("R8 idle result", res_o, 64'd0);
    issue(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
    chk("R2 addr wrap", res_o, 64'd0);
    issue(2'd0, 0, 0);
    chk("R3 addr wrap offset", {61'd0, ofs_o}, 64'd2);
  endtask

  task automatic t_addr_le();
    issue(2'd2, 64'h1000_0000_0000_0003, 64'd2);
    chk("R2 le result", res_o, 64'h1000_0000_0000_0000);
    issue(2'd0, 0, 0);
    chk("R4 le offset", {61'd0, ofs_o}, 64'd3);
    issue(2'd2, 64'h40, 64'h8);
    issue(2'd0, 0, 0);
    chk("R4 le zero wrap", {61'd0, ofs_o}, 64'd0);
    issue(2'd2, 64'd1, 64'd0);
    issue(2'd3, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF);
    chk("R4 le offset 7 used", res_o,
        ref_extract(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 7));
  endtask

  task automatic t_data_sweep(input logic [63:0] a, input logic [63:0] b);
    for (int k = 0; k < 8; k++) begin
      issue(2'd1, 64'(k), 64'd0);
      issue(2'd3, a, b);
      chk(k == 0 ? "R6 offset zero" : "R5 R7 extract", res_o, ref_extract(a, b, k));
    end
  endtask

  task automatic t_hold();
    issue(2'd1, 64'd6, 64'd0);
    issue(2'd3, 64'hAAAA, 64'h5555);
    issue(2'd0, 0, 0);
    chk("R7 hold after data", {61'd0, ofs_o}, 64'd6);
    issue(2'd0, 0, 0);
    chk("R7 hold after idle", {61'd0, ofs_o}, 64'd6);
    issue(2'd1, 64'd0, 64'd0);
    issue(2'd3, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 no lower leak", res_o, 64'd0);
  endtask

  initial begin
    #1;
    chk("R1 initial reset", {61'd0, ofs_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_addr();
    t_addr_le();
    t_data_sweep(64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF);
    t_data_sweep(64'hFEDC_BA98_7654_3210, 64'hFFFF_FFFF_FFFF_FFFF);
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule